// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

An 8-bit storage and shift register whose contents leave and enter through one shared tri-state data bus. Two mode inputs choose among hold, shift toward the high bit, shift toward the low bit and parallel load. An active-low synchronous clear overrides the mode inputs. Every update happens on the rising clock edge. During a parallel load the register samples the shared bus, so the block releases the bus by itself whenever load mode is selected. Two active-high disable inputs release the bus as well. The register keeps operating in every mode while the bus is released.

The lowest and highest bits also appear on dedicated outputs. These outputs are never released, so several registers can be chained into one longer shift word. In a chain, each stage's high-end output feeds the next stage's low-side serial input, and each stage's low-end output feeds the previous stage's high-side serial input.

Top module: `bidir_shift_reg`

## Requirements
- R1: While rst_ni is low the register is 0, independent of the clock.
- R2: If clr_ni is low at a rising clock edge, all register bits become 0 whatever mode_i is.
- R3: With clr_ni high and mode_i = 2'b00, the register keeps its value across the edge.
- R4: With clr_ni high and mode_i = 2'b01, bit n+1 takes the old bit n and bit 0 takes ser_r_i.
- R5: With clr_ni high and mode_i = 2'b10, bit n-1 takes the old bit n and bit WIDTH-1 takes ser_l_i.
- R6: With clr_ni high and mode_i = 2'b11, the register takes the value present on data_io at the edge.
- R7: When dis_i = 2'b00 and mode_i is not 2'b11, data_io is driven with the register value.
- R8: data_io is high impedance whenever dis_i[0] or dis_i[1] is high, or mode_i = 2'b11. Clear, hold, shift and load keep working in that state.
- R9: end_lo_o always equals register bit 0 and end_hi_o always equals bit WIDTH-1, whatever dis_i and mode_i are.
- R10: Two instances chained through their end outputs and serial inputs shift a 2*WIDTH-bit word correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_ni | input | 1 | Synchronous active-low clear; overrides mode_i |
| mode_i | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 parallel load |
| ser_r_i | input | 1 | Serial input into bit 0 on a shift up |
| ser_l_i | input | 1 | Serial input into bit WIDTH-1 on a shift down |
| dis_i | input | 2 | Active-high bus disables; either one releases the bus |
| data_io | inout | WIDTH | Shared bus: register output, and parallel-load input |
| end_lo_o | output | 1 | Register bit 0, always driven |
| end_hi_o | output | 1 | Register bit WIDTH-1, always driven |

## Verification
The bench asserts the clear in each of the four modes. A design that let the mode win would load, shift or hold instead of reading back zero. In every cycle where the bus should be released, the bench drives its own value onto data_io and expects to read that value back. A driver that stayed on for a single disable bit, or for load mode, would fight the bench value, and the load that follows would capture the wrong word. The end outputs are compared in every cycle, including cycles with the bus released, so an end output gated by the bus enable is caught. A two-stage chain shifts a 16-bit word a full length in each direction, which shows whether a serial input was wired to the wrong end.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } shreg_mode_e;
endpackage

// File: rtl/shreg_next_state.sv
module shreg_next_state
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             clr_ni,
  input  shreg_mode_e      mode_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic [WIDTH-1:0] load_i,
  output logic [WIDTH-1:0] q_next_o
);
  always_comb begin
    if (!clr_ni) begin
      q_next_o = '0;  // clear wins over mode
    end else begin
      unique case (mode_i)
        MODE_HOLD: q_next_o = q_i;
        MODE_SHR:  q_next_o = {q_i[WIDTH-2:0], ser_r_i};
        MODE_SHL:  q_next_o = {ser_l_i, q_i[WIDTH-1:1]};
        MODE_LOAD: q_next_o = load_i;
        default:   q_next_o = q_i;
      endcase
    end
  end
endmodule

// File: rtl/shreg_bus_drv.sv
module shreg_bus_drv
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned N_DIS = 2
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic [N_DIS-1:0] dis_i,
  input  shreg_mode_e      mode_i,
  inout  wire  [WIDTH-1:0] bus_io,
  output logic [WIDTH-1:0] bus_o
);
  logic drv_en;

  // release in load mode so external data can be sampled
  assign drv_en = ~(|dis_i) && (mode_i != MODE_LOAD);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bus_io[i] = drv_en ? q_i[i] : 1'bz;
  end

  assign bus_o = bus_io;
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import shreg_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic [1:0]       mode_i,
  input  logic             ser_r_i,
  input  logic             ser_l_i,
  input  logic [1:0]       dis_i,
  inout  wire  [WIDTH-1:0] data_io,
  output logic             end_lo_o,
  output logic             end_hi_o
);
  localparam int unsigned MSB = WIDTH - 1;

  shreg_mode_e      mode;
  logic [WIDTH-1:0] q_q, q_d, bus_rd;

  assign mode = shreg_mode_e'(mode_i);

  shreg_bus_drv #(.WIDTH(WIDTH), .N_DIS(2)) i_bus_drv (
    .q_i    (q_q),
    .dis_i  (dis_i),
    .mode_i (mode),
    .bus_io (data_io),
    .bus_o  (bus_rd)
  );

  shreg_next_state #(.WIDTH(WIDTH)) i_next (
    .q_i      (q_q),
    .clr_ni   (clr_ni),
    .mode_i   (mode),
    .ser_r_i  (ser_r_i),
    .ser_l_i  (ser_l_i),
    .load_i   (bus_rd),
    .q_next_o (q_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign end_lo_o = q_q[0];
  assign end_hi_o = q_q[MSB];

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (q_q == '0)); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && mode_i == 2'b00) |=> $stable(q_q)); // R3
  AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && mode_i == 2'b01) |=> (q_q == {$past(q_q[MSB-1:0]), $past(ser_r_i)})); // R4
  AST_SHIFT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && mode_i == 2'b10) |=> (q_q == {$past(ser_l_i), $past(q_q[MSB:1])})); // R5
  AST_LOAD_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && mode_i == 2'b11) |=> (q_q == $past(data_io))); // R6
  AST_BUS_SHOWS_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i == 2'b00 && mode_i != 2'b11) |-> (data_io == q_q)); // R7
endmodule

// File: tb/test_bidir_shift_reg.sv
`timescale 1ns/1ps
module test_bidir_shift_reg;
  localparam int W = 8;

  logic clk = 0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- single instance ----------------
  logic rst_n, clr_n, sr, sl;
  logic [1:0] mode, dis;
  logic [W-1:0] tb_bus;
  logic tb_drv;
  wire  [W-1:0] bus;
  wire end_lo, end_hi;
  assign bus = tb_drv ? tb_bus : 'z;

  bidir_shift_reg #(.WIDTH(W)) i_bidir_shift_reg (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .mode_i(mode),
    .ser_r_i(sr), .ser_l_i(sl), .dis_i(dis), .data_io(bus),
    .end_lo_o(end_lo), .end_hi_o(end_hi));

  logic [W-1:0] exp_q;

  function automatic logic [W-1:0] ref_next(logic [W-1:0] q, logic c, logic [1:0] m,
                                            logic r, logic l, logic [W-1:0] b);
    if (!c) return '0;
    case (m)
      2'b00: return q;
      2'b01: return {q[W-2:0], r};
      2'b10: return {l, q[W-1:1]};
      default: return b;
    endcase
  endfunction

  // called just after a negedge; returns just after the next negedge
  task automatic step(input logic c, input logic [1:0] m, input logic [1:0] d,
                      input logic r, input logic l, input logic [W-1:0] bv, input string req);
    clr_n = c; mode = m; dis = d; sr = r; sl = l; tb_bus = bv;
    tb_drv = (m == 2'b11) || (d != 2'b00);
    #1;
    if (tb_drv) chk({"R8 bus released ", req}, bus, bv);
    else        chk({"R7 bus drives reg ", req}, bus, exp_q);
    chk({"R9 end_lo ", req}, end_lo, exp_q[0]);
    chk({"R9 end_hi ", req}, end_hi, exp_q[W-1]);
    @(posedge clk);
    exp_q = ref_next(exp_q, c, m, r, l, bv);
    @(negedge clk);
  endtask

  // ---------------- cascade ----------------
  logic c_rst_n, c_clr_n, c_sin;
  logic [1:0] c_mode;
  logic [W-1:0] c_bus_lo_v, c_bus_hi_v;
  logic c_drv;
  wire [W-1:0] c_bus_lo, c_bus_hi;
  wire lo_end_lo, lo_end_hi, hi_end_lo, hi_end_hi;
  assign c_bus_lo = c_drv ? c_bus_lo_v : 'z;
  assign c_bus_hi = c_drv ? c_bus_hi_v : 'z;

  bidir_shift_reg #(.WIDTH(W)) i_casc_lo (
    .clk_i(clk), .rst_ni(c_rst_n), .clr_ni(c_clr_n), .mode_i(c_mode),
    .ser_r_i(c_sin), .ser_l_i(hi_end_lo), .dis_i(2'b00), .data_io(c_bus_lo),
    .end_lo_o(lo_end_lo), .end_hi_o(lo_end_hi));
  bidir_shift_reg #(.WIDTH(W)) i_casc_hi (
    .clk_i(clk), .rst_ni(c_rst_n), .clr_ni(c_clr_n), .mode_i(c_mode),
    .ser_r_i(lo_end_hi), .ser_l_i(c_sin), .dis_i(2'b00), .data_io(c_bus_hi),
    .end_lo_o(hi_end_lo), .end_hi_o(hi_end_hi));

  task automatic casc_run(input logic [1:0] m, input logic [2*W-1:0] start, input string req);
    logic [2*W-1:0] w;
    c_mode = 2'b11; c_drv = 1; c_bus_lo_v = start[W-1:0]; c_bus_hi_v = start[2*W-1:W];
    @(negedge clk); c_drv = 0; w = start;
    for (int k = 0; k < 2*W; k++) begin
      c_mode = m; c_sin = 1'($urandom);
      @(posedge clk);
      w = (m == 2'b01) ? {w[2*W-2:0], c_sin} : {c_sin, w[2*W-1:1]};
      @(negedge clk);
    end
    c_mode = 2'b00; #1;
    chk({"R10 cascade ", req}, {c_bus_hi, c_bus_lo}, w);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; clr_n = 1; mode = 0; dis = 0; sr = 0; sl = 0; tb_bus = 0; tb_drv = 0;
    c_rst_n = 0; c_clr_n = 1; c_mode = 0; c_sin = 0; c_drv = 0; c_bus_lo_v = 0; c_bus_hi_v = 0;
    exp_q = '0;
    repeat (2) @(negedge clk);
    #1 chk("R1 reset value", bus, 8'h00);
    rst_n = 1; c_rst_n = 1;
    @(negedge clk);

    // directed: load, shifts, hold
    step(1, 2'b11, 2'b00, 0, 0, 8'hA5, "R6 load A5");
    chk("R6 loaded A5", exp_q, 8'hA5);
    step(1, 2'b01, 2'b00, 1, 0, 8'h00, "R4 shr");
    step(1, 2'b10, 2'b00, 0, 1, 8'h00, "R5 shl");
    step(1, 2'b00, 2'b00, 0, 0, 8'h00, "R3 hold");
    step(1, 2'b00, 2'b00, 0, 0, 8'h00, "R3 hold check");
    // clear in every mode
    for (int m = 0; m < 4; m++) begin
      step(1, 2'b11, 2'b00, 0, 0, 8'hFF, "R6 preload");
      step(0, 2'(m), 2'b00, 1, 1, 8'hFF, "R2 clear");
      step(1, 2'b00, 2'b00, 0, 0, 8'h00, "R2 after clear");
      chk("R2 clear beats mode", bus, 8'h00);
    end
    // operations with bus released by each disable bit
    step(1, 2'b11, 2'b01, 0, 0, 8'h3C, "R8 load dis0");
    step(1, 2'b01, 2'b10, 1, 0, 8'hC3, "R8 shr dis1");
    step(1, 2'b10, 2'b11, 0, 0, 8'h5A, "R8 shl dis both");
    step(1, 2'b00, 2'b00, 0, 0, 8'h00, "R8 readback");

    // random
    for (int i = 0; i < 600; i++) begin
      logic c;
      c = ($urandom_range(0, 9) != 0);
      step(c, 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), "random");
    end

    // async reset mid-run
    step(1, 2'b11, 2'b00, 0, 0, 8'h81, "R6 preload");
    #2 rst_n = 0; #1;
    chk("R1 async reset", end_lo, 1'b0);
    chk("R1 async reset hi", end_hi, 1'b0);
    @(negedge clk); rst_n = 1; exp_q = '0;
    step(1, 2'b00, 2'b00, 0, 0, 8'h00, "R1 after reset");

    // cascade
    c_clr_n = 0; @(negedge clk); c_clr_n = 1;
    casc_run(2'b01, 16'hB00C, "up");
    casc_run(2'b10, 16'h1F35, "down");
    casc_run(2'b01, 16'h8001, "up edge");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule